// File: doc/BRIEF.md
# Loop Stability Margin Search

This block extracts the two stability-margin points of a digitally controlled converter loop from an identified plant frequency response. After a start pulse it reads one bin at a time, in ascending order, from two synchronous memories: the identified plant response Gvd and the fixed compensator response H. For each bin it forms the complex loop gain T = Gvd·H. It rates the bin's closeness to unity loop gain with a squared-magnitude error, and it inspects the signs of T to detect the −180° crossing.

When the scan ends, the block presents the bin index and the complex loop gain of the best crossover bin, which a host uses to derive phase margin. It also presents the bin index and complex loop gain of the −180° bin, which the host uses to derive gain margin, together with a flag that is set when no such bin exists. A one-cycle done pulse marks the moment these results become valid. The block uses no arctangent, no square root and no decibel conversion. Data is signed fixed point with FRAC fractional bits.

Top module: `stab_margin_search`

## Requirements
- R1: While reset is held and after it is released, done is low, gm_none is low and every result output is zero.
- R2: After start is accepted, rd_addr presents bin 0, 1, 2, … in order. Each bin occupies five cycles, and read data is taken one cycle after its address is presented.
- R3: pm_bin is the bin with the smallest |(Gre²+Gim²)·(Hre²+Him²) − 2^(4·FRAC)|. When two bins tie, the lower bin index is kept.
- R4: pm_re and pm_im are Re{T} = Gre·Hre − Gim·Him and Im{T} = Gre·Him + Gim·Hre of the pm bin, kept at full precision with scale 2^(2·FRAC).
- R5: gm_bin is the first bin k ≥ 1 for which Im{T(k−1)} < 0, Im{T(k)} ≥ 0 and Re{T(k)} < 0. gm_re and gm_im hold T of that bin.
- R6: When no bin meets the R5 condition, gm_none is 1 and gm_bin, gm_re and gm_im are 0.
- R7: done is high for exactly one cycle, 5·N+2 clock edges after the edge that samples start, where N is the bin count. All results are valid while done is high.
- R8: num_bins (1 to MAX_BINS) is captured when start is accepted. No address at or above that count is presented, and rd_addr rests at N−1 after the scan.
- R9: A start pulse or a change to num_bins while a scan is running has no effect. The running scan finishes with its own count and timing, and only one done pulse is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a scan when the block is idle |
| num_bins | input | CW | Number of bins to scan, 1 to MAX_BINS |
| rd_addr | output | AW | Bin address shared by both memories |
| g_re | input | DW | Plant response, real part (signed) |
| g_im | input | DW | Plant response, imaginary part (signed) |
| h_re | input | DW | Compensator response, real part (signed) |
| h_im | input | DW | Compensator response, imaginary part (signed) |
| pm_bin | output | AW | Crossover bin index |
| pm_re | output | PW | Re{T} at the crossover bin |
| pm_im | output | PW | Im{T} at the crossover bin |
| gm_bin | output | AW | −180° bin index |
| gm_re | output | PW | Re{T} at the −180° bin |
| gm_im | output | PW | Im{T} at the −180° bin |
| gm_none | output | 1 | No −180° bin was found |
| done | output | 1 | One-cycle pulse: results valid |

## Verification
The hardest situations to reach from the ports are a scan that sees several −180° crossings, where only the first may be kept, and a start pulse that arrives mid-scan together with a changed bin count. The stimulus builds a response whose imaginary part alternates in sign while its real part stays negative. During that scan it pulses start and shrinks num_bins, then confirms that the result, the done timing and the address walk all belong to the original scan. Separate scans cover an exact error tie between two bins, crossings with a positive real part (which must be ignored), a single-bin scan, and a full 512-bin pseudo-random scan.

// File: rtl/stab_margin_search.sv
module stab_margin_search #(
  parameter int DW       = 16,
  parameter int FRAC     = 12,
  parameter int MAX_BINS = 512,
  localparam int AW = $clog2(MAX_BINS),
  localparam int CW = $clog2(MAX_BINS + 1),
  localparam int PW = 2 * DW + 1,
  localparam int MW = 2 * DW + 1,
  localparam int EW = 2 * MW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [CW-1:0]        num_bins,
  output logic [AW-1:0]        rd_addr,
  input  logic signed [DW-1:0] g_re,
  input  logic signed [DW-1:0] g_im,
  input  logic signed [DW-1:0] h_re,
  input  logic signed [DW-1:0] h_im,
  output logic [AW-1:0]        pm_bin,
  output logic signed [PW-1:0] pm_re,
  output logic signed [PW-1:0] pm_im,
  output logic [AW-1:0]        gm_bin,
  output logic signed [PW-1:0] gm_re,
  output logic signed [PW-1:0] gm_im,
  output logic                 gm_none,
  output logic                 done
);

  localparam logic signed [EW-1:0] UNITY = EW'(1) <<< (4 * FRAC);

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CALC_T, S_CALC_ERR, S_SIGNS, S_LAST, S_OUT_PM, S_OUT_GM
  } state_t;

  state_t st;
  logic [AW-1:0] idx, last_idx, best_bin, cross_bin;
  logic signed [PW-1:0] t_re, t_im, prev_im, best_re, best_im, cross_re, cross_im;
  logic signed [MW-1:0] g_mag, h_mag;
  logic [EW-1:0] best_err;
  logic cross_found;

  logic signed [PW-1:0] t_re_n, t_im_n;
  logic signed [MW-1:0] g_mag_n, h_mag_n;
  logic signed [EW-1:0] err_s;
  logic [EW-1:0] err_abs;
  logic is_cross;

  assign t_re_n  = PW'(g_re) * PW'(h_re) - PW'(g_im) * PW'(h_im);
  assign t_im_n  = PW'(g_re) * PW'(h_im) + PW'(g_im) * PW'(h_re);
  assign g_mag_n = MW'(g_re) * MW'(g_re) + MW'(g_im) * MW'(g_im);
  assign h_mag_n = MW'(h_re) * MW'(h_re) + MW'(h_im) * MW'(h_im);
  assign err_s   = EW'(g_mag) * EW'(h_mag) - UNITY;
  assign err_abs = err_s[EW-1] ? EW'(-err_s) : EW'(err_s);
  assign is_cross = (idx != '0) && prev_im[PW-1] && !t_im[PW-1] && t_re[PW-1];
  assign rd_addr = idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      idx <= '0; last_idx <= '0;
      best_bin <= '0; cross_bin <= '0;
      t_re <= '0; t_im <= '0; prev_im <= '0;
      best_re <= '0; best_im <= '0; cross_re <= '0; cross_im <= '0;
      g_mag <= '0; h_mag <= '0; best_err <= '0; cross_found <= 1'b0;
      pm_bin <= '0; pm_re <= '0; pm_im <= '0;
      gm_bin <= '0; gm_re <= '0; gm_im <= '0;
      gm_none <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          idx <= '0;
          last_idx <= AW'(num_bins - CW'(1));
          cross_found <= 1'b0;
          st <= S_FETCH;
        end
        S_FETCH: st <= S_CALC_T;
        S_CALC_T: begin
          t_re <= t_re_n; t_im <= t_im_n;
          g_mag <= g_mag_n; h_mag <= h_mag_n;
          st <= S_CALC_ERR;
        end
        S_CALC_ERR: begin
          if (idx == '0 || err_abs < best_err) begin
            best_err <= err_abs; best_bin <= idx;
            best_re <= t_re; best_im <= t_im;
          end
          st <= S_SIGNS;
        end
        S_SIGNS: begin
          if (!cross_found && is_cross) begin
            cross_found <= 1'b1; cross_bin <= idx;
            cross_re <= t_re; cross_im <= t_im;
          end
          prev_im <= t_im;
          st <= S_LAST;
        end
        S_LAST: if (idx == last_idx) st <= S_OUT_PM;
                else begin idx <= idx + AW'(1); st <= S_FETCH; end
        S_OUT_PM: begin
          pm_bin <= best_bin; pm_re <= best_re; pm_im <= best_im;
          st <= S_OUT_GM;
        end
        S_OUT_GM: begin
          gm_none <= !cross_found;
          gm_bin <= cross_found ? cross_bin : '0;
          gm_re  <= cross_found ? cross_re  : '0;
          gm_im  <= cross_found ? cross_im  : '0;
          done <= 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_addr_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |-> (rd_addr <= last_idx));
  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LAST && idx != last_idx) |=> (rd_addr == $past(rd_addr) + AW'(1)));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_gm_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && gm_none) |-> (gm_bin == '0 && gm_re == '0 && gm_im == '0));
  assert_pm_in_scan_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pm_bin <= last_idx));
  assert_gm_left_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !gm_none) |-> (gm_re < 0 && gm_im >= 0 && gm_bin != '0));
  assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && st != S_IDLE && st != S_LAST) |=> (st != S_FETCH));

endmodule

// File: tb/stab_margin_search_test.sv
module stab_margin_search_test;
  localparam int DW = 16, FRAC = 12, MAXB = 512, AW = 9, CW = 10, PW = 33;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start, done, gm_none;
  logic [CW-1:0] num_bins;
  logic [AW-1:0] rd_addr, pm_bin, gm_bin;
  logic signed [DW-1:0] g_re, g_im, h_re, h_im;
  logic signed [PW-1:0] pm_re, pm_im, gm_re, gm_im;

  stab_margin_search #(.DW(DW), .FRAC(FRAC), .MAX_BINS(MAXB)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .num_bins(num_bins), .rd_addr(rd_addr),
    .g_re(g_re), .g_im(g_im), .h_re(h_re), .h_im(h_im),
    .pm_bin(pm_bin), .pm_re(pm_re), .pm_im(pm_im),
    .gm_bin(gm_bin), .gm_re(gm_re), .gm_im(gm_im), .gm_none(gm_none), .done(done));

  logic signed [DW-1:0] mgr [MAXB];
  logic signed [DW-1:0] mgi [MAXB];
  logic signed [DW-1:0] mhr [MAXB];
  logic signed [DW-1:0] mhi [MAXB];

  always @(posedge clk) begin
    g_re <= mgr[rd_addr]; g_im <= mgi[rd_addr];
    h_re <= mhr[rd_addr]; h_im <= mhi[rd_addr];
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0, runs_seen = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  typedef struct {
    int due;
    longint pm_bin, pm_re, pm_im, gm_bin, gm_re, gm_im, gm_none;
  } exp_t;
  exp_t sb[$];

  function automatic exp_t model(int n);
    exp_t e;
    longint best = 0, pim = 0;
    bit found = 0;
    e.gm_bin = 0; e.gm_re = 0; e.gm_im = 0; e.pm_bin = 0; e.pm_re = 0; e.pm_im = 0;
    e.due = 0;
    for (int k = 0; k < n; k++) begin
      longint gr = longint'(mgr[k]), gi = longint'(mgi[k]);
      longint hr = longint'(mhr[k]), hi = longint'(mhi[k]);
      longint tr = gr * hr - gi * hi;
      longint ti = gr * hi + gi * hr;
      longint er = (gr * gr + gi * gi) * (hr * hr + hi * hi) - (64'sd1 <<< (4 * FRAC));
      if (er < 0) er = -er;
      if (k == 0 || er < best) begin
        best = er; e.pm_bin = k; e.pm_re = tr; e.pm_im = ti;
      end
      if (!found && k > 0 && pim < 0 && ti >= 0 && tr < 0) begin
        found = 1; e.gm_bin = k; e.gm_re = tr; e.gm_im = ti;
      end
      pim = ti;
    end
    e.gm_none = found ? 0 : 1;
    return e;
  endfunction

  task automatic set_bin(int k, int gr, int gi, int hr, int hi);
    mgr[k] = DW'(gr); mgi[k] = DW'(gi); mhr[k] = DW'(hr); mhi[k] = DW'(hi);
  endtask

  task automatic run(int n, bit glitch);
    exp_t e = model(n);
    int c0, r0;
    int bad = 0;
    @(negedge clk);
    r0 = runs_seen;
    c0 = cyc;
    num_bins = CW'(n);
    start = 1'b1;
    e.due = c0 + 1 + 5 * n + 2;
    sb.push_back(e);
    @(negedge clk);
    start = 1'b0;
    for (int b = 0; b < n; b++) begin
      while (cyc < c0 + 2 + 5 * b) @(negedge clk);
      if (int'(rd_addr) != b) bad++;
      if (glitch && b == 1) begin
        start = 1'b1; num_bins = CW'(3);
        @(negedge clk);
        start = 1'b0;
      end
    end
    chk("R2", "address walk mismatches", bad, 0);
    while (runs_seen == r0) @(negedge clk);
    chk("R8", "rd_addr after scan", longint'(rd_addr), n - 1);
    repeat (3) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1 && done === 1'b1) begin
      if (sb.size() == 0) begin
        chk("R9", "unexpected done pulse", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk("R7", "done cycle", cyc, e.due);
        chk("R3", "pm_bin", longint'(pm_bin), e.pm_bin);
        chk("R4", "pm_re", longint'(pm_re), e.pm_re);
        chk("R4", "pm_im", longint'(pm_im), e.pm_im);
        chk("R5", "gm_bin", longint'(gm_bin), e.gm_bin);
        chk("R5", "gm_re", longint'(gm_re), e.gm_re);
        chk("R5", "gm_im", longint'(gm_im), e.gm_im);
        chk("R6", "gm_none", longint'(gm_none), e.gm_none);
      end
      runs_seen++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R7 watchdog: actual %0d cycles expected completion", cyc);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; num_bins = '0;
    for (int k = 0; k < MAXB; k++) set_bin(k, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk("R1", "done in reset", longint'(done), 0);
    chk("R1", "gm_none in reset", longint'(gm_none), 0);
    chk("R1", "pm_re in reset", longint'(pm_re), 0);
    chk("R1", "gm_bin in reset", longint'(gm_bin), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "done after reset", longint'(done), 0);

    // R3 R5: phase sweeping through -180 with falling magnitude
    set_bin(0, 0, -8000, 4096, 0);     set_bin(1, -2000, -6000, 4096, 0);
    set_bin(2, -4000, -3000, 4096, 0); set_bin(3, -4200, -500, 4096, 0);
    set_bin(4, -3000, 1000, 4096, 0);  set_bin(5, -1500, 1500, 4096, 0);
    set_bin(6, -500, 800, 4096, 0);    set_bin(7, -200, 100, 4096, 0);
    run(8, 0);

    // R3 tie: bins 2 and 4 both exact unity; R6 no crossing
    for (int k = 0; k < 6; k++) set_bin(k, 2048, 0, 0, 4096);
    set_bin(2, 0, 4096, 0, 4096);
    set_bin(4, 0, 4096, 0, 4096);
    run(6, 0);

    // single bin
    set_bin(0, -1234, 567, 3000, -2000);
    run(1, 0);

    // R5 first of many crossings, with R9 start glitch mid-scan
    for (int k = 0; k < 10; k++) set_bin(k, -3000, (k % 2 == 0) ? -1000 : 1000, 4096, 0);
    run(10, 1);

    // R5 crossings with positive real part are ignored -> R6
    for (int k = 0; k < 4; k++) set_bin(k, 3000, (k % 2 == 0) ? -1000 : 1000, 4096, 0);
    run(4, 0);

    // full-length pseudo-random scan
    for (int k = 0; k < MAXB; k++)
      set_bin(k, int'($urandom_range(16383)) - 8192, int'($urandom_range(16383)) - 8192,
                 int'($urandom_range(16383)) - 8192, int'($urandom_range(16383)) - 8192);
    run(512, 0);

    chk("R9", "scoreboard left over", sb.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule